// File: doc/BRIEF.md
# DMA Descriptor Chain Fetch Engine

This block fetches DMA transfer descriptors from memory one 16-bit word at a time. It decodes each word into a channel parameter set: start address, control word, inner count and step, and outer count and step. When a descriptor is complete and enabled, it raises a one-cycle load strobe so that an address generator can take the parameters. It then stays quiet until the transfer-done input reports the end of the current transfer, and only then does it fetch the next descriptor.

Three memory layouts are supported.
- **Packed array:** descriptors are contiguous and carry no link words.
- **Short-link list:** a 16-bit link gives the low half of the next address, and a page register supplies the upper half.
- **Long-link list:** a full 32-bit link is stored upper half first.

A two-dimensional flag selects whether the outer-loop words are present in each descriptor. A link may point back to an earlier descriptor, which forms an endless ring.

A descriptor whose control word has its enable bit clear parks the channel in a stalled state. Software can rewrite that descriptor and pulse the kick input, and the engine then fetches the same descriptor again.

Top module: `dfe_chain_fetch`

## Requirements
- R1: After reset, rd_req, prm_load, stalled and align_err are all 0.
- R2: With cfg_layout=0 (packed array), the words are read in this order from consecutive addresses base, base+2, and so on: start-low, start-high, control, inner count, inner step, outer count, outer step. The next descriptor begins at base + 2*length.
- R3: With cfg_layout=1 (short-link), word 0 is the low 16 bits of the next pointer. The upper 16 bits come from cfg_page_hi, and the five or seven parameter words follow.
- R4: With cfg_layout=2 (long-link), word 0 is the upper half of the next pointer and word 1 is the lower half, followed by the parameter words.
- R5: With cfg_two_d=0, the two outer-loop words are not fetched, so each descriptor is 2 words shorter. In that case prm_ycount reads 1 and prm_ystep reads 0.
- R6: When the last word of a descriptor has returned and control bit 0 (enable) is 1, prm_load pulses high for exactly one cycle while the parameter outputs hold that descriptor's values.
- R7: After prm_load, no read request is issued until xfer_done is seen high. The next request then targets the next descriptor pointer.
- R8: If control bit 0 is 0, stalled goes high, no load strobe is given, and no reads occur. A kick while stalled re-fetches the same descriptor from its first word.
- R9: A link that points back to the first descriptor makes the chain repeat indefinitely.
- R10: If a next pointer has bit 0 set, align_err goes high and reads stop. A kick with a new first pointer clears align_err and restarts the fetch.
- R11: A kick while a descriptor is being fetched or is in use has no effect on the chain.
- R12: At most one read is outstanding, so rd_req is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_layout | input | 2 | 0 packed array, 1 short-link, 2 or 3 long-link; sampled on kick from idle |
| cfg_two_d | input | 1 | Descriptor carries outer-loop words; sampled on kick from idle |
| cfg_first_ptr | input | 32 | Byte address of the first descriptor |
| cfg_page_hi | input | 16 | Upper pointer half for the short-link layout |
| kick | input | 1 | Start pulse from idle or error, or restart pulse when stalled |
| xfer_done | input | 1 | Current descriptor's transfer has finished |
| rd_req | output | 1 | Memory read request for one 16-bit word |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 16 | Read data word |
| prm_load | output | 1 | One-cycle strobe: the parameter set is ready |
| prm_start_addr | output | 32 | Transfer start address |
| prm_ctrl | output | 16 | Control word; bit 0 is the enable bit |
| prm_xcount | output | 16 | Inner-loop count |
| prm_xstep | output | 16 | Inner-loop step |
| prm_ycount | output | 16 | Outer-loop count (1 when the outer words are omitted) |
| prm_ystep | output | 16 | Outer-loop step (0 when the outer words are omitted) |
| stalled | output | 1 | Channel is parked on a disabled descriptor |
| align_err | output | 1 | A next pointer was odd; fetching has stopped |

## Verification
The fetch path is driven once for each combination of the three layouts with the outer-loop words present or absent. Each descriptor has distinct field values, so a word landing in the wrong field is visible, and the address of the next fetch tells apart the link-word placement, the page register and the implicit packed-array stride. Directed cases cover the remaining behaviours:
- a disabled descriptor that is rewritten and restarted;
- a two-entry ring, with a stray kick issued while a descriptor is in use;
- an odd link pointer, which must stop the reads.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BUSY,
        ST_STALL,
        ST_ERR
    } dfe_state_e;

    typedef enum logic [3:0] {
        FLD_NHI,
        FLD_NLO,
        FLD_SALO,
        FLD_SAHI,
        FLD_CTL,
        FLD_XC,
        FLD_XM,
        FLD_YC,
        FLD_YM
    } dfe_field_e;

endpackage

// File: rtl/dfe_word_map.sv
module dfe_word_map
    import dfe_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [1:0]    layout,
    input  logic          two_d,
    input  logic [IW-1:0] idx,
    output dfe_field_e    field,
    output logic [IW-1:0] len,
    output logic          last
);
    logic [IW-1:0] pre;
    logic [IW-1:0] j;

    always_comb begin
        pre   = layout[1] ? IW'(2) : (layout[0] ? IW'(1) : IW'(0));
        len   = pre + IW'(5) + (two_d ? IW'(2) : IW'(0));
        last  = (idx == len - IW'(1));
        j     = idx - pre;
        field = FLD_SALO;
        if (idx < pre) begin
            field = (layout[1] && idx == '0) ? FLD_NHI : FLD_NLO;
        end else begin
            case (j)
                IW'(0):  field = FLD_SALO;
                IW'(1):  field = FLD_SAHI;
                IW'(2):  field = FLD_CTL;
                IW'(3):  field = FLD_XC;
                IW'(4):  field = FLD_XM;
                IW'(5):  field = FLD_YC;
                default: field = FLD_YM;
            endcase
        end
    end
endmodule

// File: rtl/dfe_next_ptr.sv
module dfe_next_ptr #(
    parameter int DW = 16,
    parameter int IW = 4,
    localparam int AW = 2 * DW
) (
    input  logic [1:0]    layout,
    input  logic [DW-1:0] page_hi,
    input  logic [DW-1:0] link_hi,
    input  logic [DW-1:0] link_lo,
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] len,
    output logic [AW-1:0] next_ptr,
    output logic          misaligned
);
    always_comb begin
        if (layout[1]) begin
            next_ptr = {link_hi, link_lo};
        end else if (layout[0]) begin
            next_ptr = {page_hi, link_lo};
        end else begin
            next_ptr = base + {{(AW-IW-1){1'b0}}, len, 1'b0};
        end
        misaligned = next_ptr[0];
    end
endmodule

// File: rtl/dfe_chain_fetch.sv
module dfe_chain_fetch
    import dfe_pkg::*;
#(
    parameter int DW = 16,
    localparam int AW = 2 * DW,
    localparam int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_layout,
    input  logic          cfg_two_d,
    input  logic [AW-1:0] cfg_first_ptr,
    input  logic [DW-1:0] cfg_page_hi,
    input  logic          kick,
    input  logic          xfer_done,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          prm_load,
    output logic [AW-1:0] prm_start_addr,
    output logic [DW-1:0] prm_ctrl,
    output logic [DW-1:0] prm_xcount,
    output logic [DW-1:0] prm_xstep,
    output logic [DW-1:0] prm_ycount,
    output logic [DW-1:0] prm_ystep,
    output logic          stalled,
    output logic          align_err
);
    typedef struct packed {
        dfe_state_e    st;
        logic [AW-1:0] base;
        logic [IW-1:0] idx;
        logic          pend;
        logic [1:0]    layout;
        logic          two_d;
        logic [DW-1:0] nhi;
        logic [DW-1:0] nlo;
        logic [DW-1:0] salo;
        logic [DW-1:0] sahi;
        logic [DW-1:0] ctl;
        logic [DW-1:0] xc;
        logic [DW-1:0] xm;
        logic [DW-1:0] yc;
        logic [DW-1:0] ym;
        logic          load;
    } dfe_regs_t;

    dfe_regs_t     r_d, r_q;
    dfe_field_e    fld;
    logic [IW-1:0] dlen;
    logic          dlast;
    logic [AW-1:0] nxt;
    logic          nxt_odd;

    dfe_word_map #(.IW(IW)) u_map (
        .layout (r_q.layout),
        .two_d  (r_q.two_d),
        .idx    (r_q.idx),
        .field  (fld),
        .len    (dlen),
        .last   (dlast)
    );

    dfe_next_ptr #(.DW(DW), .IW(IW)) u_next (
        .layout     (r_q.layout),
        .page_hi    (cfg_page_hi),
        .link_hi    (r_q.nhi),
        .link_lo    (r_q.nlo),
        .base       (r_q.base),
        .len        (dlen),
        .next_ptr   (nxt),
        .misaligned (nxt_odd)
    );

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_ERR: begin
                if (kick) begin
                    r_d.st     = ST_FETCH;
                    r_d.base   = cfg_first_ptr;
                    r_d.idx    = '0;
                    r_d.pend   = 1'b0;
                    r_d.layout = cfg_layout;
                    r_d.two_d  = cfg_two_d;
                end
            end
            ST_FETCH: begin
                if (!r_q.pend) begin
                    r_d.pend = 1'b1;
                end else if (rd_valid) begin
                    r_d.pend = 1'b0;
                    case (fld)
                        FLD_NHI:  r_d.nhi  = rd_data;
                        FLD_NLO:  r_d.nlo  = rd_data;
                        FLD_SALO: r_d.salo = rd_data;
                        FLD_SAHI: r_d.sahi = rd_data;
                        FLD_CTL:  r_d.ctl  = rd_data;
                        FLD_XC:   r_d.xc   = rd_data;
                        FLD_XM:   r_d.xm   = rd_data;
                        FLD_YC:   r_d.yc   = rd_data;
                        default:  r_d.ym   = rd_data;
                    endcase
                    if (dlast) begin
                        // control word is never the last word, so r_q.ctl is current
                        if (r_q.ctl[0]) begin
                            r_d.st   = ST_BUSY;
                            r_d.load = 1'b1;
                        end else begin
                            r_d.st = ST_STALL;
                        end
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                    end
                end
            end
            ST_BUSY: begin
                if (xfer_done) begin
                    if (nxt_odd) begin
                        r_d.st = ST_ERR;
                    end else begin
                        r_d.st   = ST_FETCH;
                        r_d.base = nxt;
                        r_d.idx  = '0;
                        r_d.pend = 1'b0;
                    end
                end
            end
            ST_STALL: begin
                if (kick) begin
                    r_d.st   = ST_FETCH;
                    r_d.idx  = '0;
                    r_d.pend = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req         = (r_q.st == ST_FETCH) && !r_q.pend;
    assign rd_addr        = r_q.base + {{(AW-IW-1){1'b0}}, r_q.idx, 1'b0};
    assign prm_load       = r_q.load;
    assign prm_start_addr = {r_q.sahi, r_q.salo};
    assign prm_ctrl       = r_q.ctl;
    assign prm_xcount     = r_q.xc;
    assign prm_xstep      = r_q.xm;
    assign prm_ycount     = r_q.two_d ? r_q.yc : DW'(1);
    assign prm_ystep      = r_q.two_d ? r_q.ym : '0;
    assign stalled        = (r_q.st == ST_STALL);
    assign align_err      = (r_q.st == ST_ERR);

    // R12
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R6
    load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prm_load |-> prm_ctrl[0]);

    // R6
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prm_load |=> !prm_load);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !kick) |=> (stalled && !rd_req));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !rd_req);

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && !xfer_done) |=> !rd_req);

endmodule

// File: tb/tb_dfe_chain_fetch.sv
`timescale 1ns/100ps
module tb_dfe_chain_fetch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_layout;
    logic        cfg_two_d;
    logic [31:0] cfg_first_ptr;
    logic [15:0] cfg_page_hi;
    logic        kick, xfer_done;
    logic        rd_req, rd_valid;
    logic [31:0] rd_addr;
    logic [15:0] rd_data;
    logic        prm_load, stalled, align_err;
    logic [31:0] prm_start_addr;
    logic [15:0] prm_ctrl, prm_xcount, prm_xstep, prm_ycount, prm_ystep;

    always #2.5 clk = ~clk;

    dfe_chain_fetch dut (
        .clk(clk), .rst_n(rst_n), .cfg_layout(cfg_layout), .cfg_two_d(cfg_two_d),
        .cfg_first_ptr(cfg_first_ptr), .cfg_page_hi(cfg_page_hi), .kick(kick),
        .xfer_done(xfer_done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .prm_load(prm_load), .prm_start_addr(prm_start_addr),
        .prm_ctrl(prm_ctrl), .prm_xcount(prm_xcount), .prm_xstep(prm_xstep),
        .prm_ycount(prm_ycount), .prm_ystep(prm_ystep), .stalled(stalled),
        .align_err(align_err)
    );

    logic [15:0] mem [256];
    logic [31:0] log_a [64];
    int req_n = 0, ld_n = 0, b2b = 0;
    logic prev_req = 1'b0;
    int checks = 0, failures = 0;

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        rd_valid <= rd_req;
        if (rd_req) rd_data <= mem[rd_addr[8:1]];
        if (rd_req) begin
            if (req_n < 64) log_a[req_n] = rd_addr;
            req_n++;
        end
        if (rd_req && prev_req) b2b++;
        prev_req = rd_req;
        if (prm_load) ld_n++;
    end

    // {layout[2], two_d, base[16], hi_or_page[16], link_lo[16]}
    localparam logic [50:0] VEC [6] = '{
        {2'd0, 1'b1, 16'h0020, 16'h0000, 16'h0000},
        {2'd0, 1'b0, 16'h0040, 16'h0000, 16'h0000},
        {2'd1, 1'b1, 16'h0060, 16'h0001, 16'h0080},
        {2'd1, 1'b0, 16'h0070, 16'h0002, 16'h0090},
        {2'd2, 1'b1, 16'h00A0, 16'h0003, 16'h00C0},
        {2'd2, 1'b0, 16'h00B0, 16'h0000, 16'h00D0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [1:0] lay, input logic td, input logic [15:0] base,
                            input logic [15:0] hi, input logic [15:0] lo,
                            input logic [15:0] salo, input logic [15:0] sahi,
                            input logic [15:0] ctl, input logic [15:0] xc,
                            input logic [15:0] xm, input logic [15:0] yc,
                            input logic [15:0] ym);
        int a = int'(base) >> 1;
        if (lay[1]) begin mem[a & 255] = hi; mem[(a+1) & 255] = lo; a += 2; end
        else if (lay[0]) begin mem[a & 255] = lo; a += 1; end
        mem[a & 255] = salo; mem[(a+1) & 255] = sahi; mem[(a+2) & 255] = ctl;
        mem[(a+3) & 255] = xc; mem[(a+4) & 255] = xm;
        if (td) begin mem[(a+5) & 255] = yc; mem[(a+6) & 255] = ym; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; kick = 1'b0; xfer_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        req_n = 0; ld_n = 0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic wait_load(output logic got);
        got = 1'b0;
        for (int k = 0; k < 200 && !got; k++) begin
            @(negedge clk);
            if (prm_load) got = 1'b1;
        end
    endtask

    task automatic wait_req(input int n);
        for (int k = 0; k < 40 && req_n <= n; k++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic got;
        string tg;
        for (int m = 0; m < 256; m++) mem[m] = 16'h0;
        rst_n = 1'b0; kick = 1'b0; xfer_done = 1'b0;
        cfg_layout = 2'd0; cfg_two_d = 1'b1; cfg_first_ptr = '0; cfg_page_hi = '0;
        repeat (3) @(negedge clk);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 prm_load", prm_load, 0);
        chk("R1 stalled", stalled, 0);
        chk("R1 align_err", align_err, 0);
        rst_n = 1'b1;

        // table walk: every layout with and without outer-loop words
        for (int i = 0; i < 6; i++) begin
            logic [1:0]  lay;
            logic        td;
            logic [15:0] base, hi, lo;
            logic [31:0] exp_next;
            int len;
            {lay, td, base, hi, lo} = VEC[i];
            len = (lay[1] ? 2 : (lay[0] ? 1 : 0)) + 5 + (td ? 2 : 0);
            tg = lay[1] ? "R4" : (lay[0] ? "R3" : "R2");
            exp_next = lay == 2'd0 ? {16'h0, base + 16'(2*len)} : {hi, lo};
            do_reset();
            put_desc(lay, td, base, hi, lo, base ^ 16'h1111, 16'h2000 + 16'(i),
                     16'h0001 | 16'(i << 4), 16'h0010 + 16'(i), 16'h0002,
                     16'h0003 + 16'(i), 16'hFFF0 - 16'(i));
            cfg_layout = lay; cfg_two_d = td; cfg_first_ptr = {16'h0, base}; cfg_page_hi = hi;
            pulse_kick();
            wait_load(got);
            chk("R6 load strobe", got, 1);
            chk({tg, " word count"}, req_n, td ? len : len);
            chk({tg, " first addr"}, log_a[0], {16'h0, base});
            chk({tg, " last addr"}, log_a[len-1], {16'h0, base + 16'(2*(len-1))});
            chk({tg, " start addr"}, prm_start_addr, {16'h2000 + 16'(i), base ^ 16'h1111});
            chk({tg, " ctrl"}, prm_ctrl, 16'h0001 | 16'(i << 4));
            chk({tg, " xcount"}, prm_xcount, 16'h0010 + 16'(i));
            chk(td ? "R2 ycount" : "R5 ycount", prm_ycount, td ? 16'h0003 + 16'(i) : 16'h1);
            chk(td ? "R2 ystep" : "R5 ystep", prm_ystep, td ? 16'hFFF0 - 16'(i) : 16'h0);
            @(negedge clk);
            chk("R6 strobe one cycle", prm_load, 0);
            repeat (6) @(negedge clk);
            chk("R7 quiet before done", req_n, len);
            pulse_done();
            wait_req(len);
            chk({tg, " next pointer"}, log_a[len], exp_next);
        end

        // R8: disabled descriptor stalls, restart refetches it
        do_reset();
        put_desc(2'd0, 1'b1, 16'h0100, 16'h0, 16'h0, 16'h1234, 16'h0005, 16'h0000,
                 16'h0007, 16'h0001, 16'h0002, 16'h0003);
        cfg_layout = 2'd0; cfg_two_d = 1'b1; cfg_first_ptr = 32'h100;
        pulse_kick();
        for (int k = 0; k < 60 && !stalled; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R8 stalled", stalled, 1);
        chk("R8 no load", ld_n, 0);
        chk("R8 reads stop", req_n, 7);
        mem[(16'h100 >> 1) + 2] = 16'h0001;
        pulse_kick();
        wait_load(got);
        chk("R8 load after restart", got, 1);
        chk("R8 refetch address", log_a[7], 32'h100);
        chk("R8 stall cleared", stalled, 0);

        // R9 ring of two long-link descriptors, R11 stray kick while busy
        do_reset();
        put_desc(2'd2, 1'b1, 16'h0140, 16'h0, 16'h0160, 16'hAAAA, 16'h0, 16'h0001,
                 16'h1, 16'h1, 16'h1, 16'h1);
        put_desc(2'd2, 1'b1, 16'h0160, 16'h0, 16'h0140, 16'hBBBB, 16'h0, 16'h0001,
                 16'h1, 16'h1, 16'h1, 16'h1);
        cfg_layout = 2'd2; cfg_two_d = 1'b1; cfg_first_ptr = 32'h140;
        pulse_kick();
        wait_load(got);
        chk("R9 first desc", prm_start_addr[15:0], 16'hAAAA);
        cfg_first_ptr = 32'h1C0;
        pulse_kick();
        repeat (3) @(negedge clk);
        chk("R11 kick ignored", req_n, 9);
        pulse_done();
        wait_load(got);
        chk("R11 chain kept", log_a[9], 32'h160);
        chk("R9 second desc", prm_start_addr[15:0], 16'hBBBB);
        pulse_done();
        wait_load(got);
        chk("R9 wrap address", log_a[18], 32'h140);
        chk("R9 wrap desc", prm_start_addr[15:0], 16'hAAAA);

        // R10 odd link pointer
        do_reset();
        put_desc(2'd1, 1'b0, 16'h0180, 16'h0, 16'h0191, 16'h0, 16'h0, 16'h0001,
                 16'h1, 16'h1, 16'h1, 16'h1);
        cfg_layout = 2'd1; cfg_two_d = 1'b0; cfg_first_ptr = 32'h180; cfg_page_hi = 16'h0;
        pulse_kick();
        wait_load(got);
        pulse_done();
        repeat (8) @(negedge clk);
        chk("R10 align_err", align_err, 1);
        chk("R10 reads stop", req_n, 6);
        pulse_kick();
        @(negedge clk);
        chk("R10 error cleared", align_err, 0);
        wait_load(got);
        chk("R10 restart loads", got, 1);

        chk("R12 single outstanding", b2b, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule